// File: doc/BRIEF.md
# Lane-Partitioned Byte Right Shifter

This block shifts a 512-bit vector toward its least significant end by a whole number of bytes. The vector is cut into 128-bit lanes and each lane is shifted on its own, using the same byte count. Bytes never move from one lane into its neighbour, and the bytes vacated at the top of each lane become zero. A count of sixteen or more empties every active lane.

A two-bit width select decides how many lanes take part: one, two or all four. Bits above the active width are cleared. A preserve-upper flag, honoured only at the narrowest width, changes this rule. In that mode the lowest lane is shifted from the prior destination value rather than from the source, and all bits above it keep the prior destination contents. The result goes through an output register by default, with a valid bit that follows the input valid one cycle later. A parameter can remove the register, which makes the path purely combinational.

Top module: `lane_bsr_top`

## Requirements
- R1: For each active lane, result byte j (0..15) equals byte j+N of the same lane's input when j+N < 16, where N is the byte count (bit shift = 8*N).
- R2: The vacated high-order bytes of every active lane, bytes 16-N..15, are zero.
- R3: Any count greater than 15, up to 255, makes every active lane all zeros.
- R4: Lanes are shifted independently. No byte from a higher lane ever appears in a lower lane.
- R5: With width_sel = 2'b00 and keep_upper = 0, only bits [127:0] are shifted from the source, and result bits [511:128] are zero.
- R6: With width_sel = 2'b01, lanes [127:0] and [255:128] are shifted, and result bits [511:256] are zero.
- R7: With width_sel = 2'b10 or 2'b11, all four lanes are shifted.
- R8: With width_sel = 2'b00 and keep_upper = 1, bits [127:0] are the shift of prior_dst[127:0], and bits [511:128] equal prior_dst[511:128].
- R9: keep_upper has no effect when width_sel is not 2'b00.
- R10: In registered mode, a result accepted with in_valid appears one cycle later with out_valid = 1. A cycle without in_valid gives out_valid = 0 in the following cycle and leaves result unchanged.
- R11: While reset is asserted, out_valid and result are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| src_vec | input | 512 | Source vector |
| prior_dst | input | 512 | Prior destination contents |
| byte_cnt | input | 8 | Unsigned shift count in bytes |
| width_sel | input | 2 | 00 = 128, 01 = 256, 10/11 = 512 bits |
| keep_upper | input | 1 | Preserve-upper mode (used only at 128-bit width) |
| out_valid | output | 1 | Result is valid |
| result | output | 512 | Shifted result |

## Verification
The bench drives counts on both sides of the saturation edge (15, 16, 255) and the zero count. A design that only looked at the low four bits of the count would wrap 16 back to an unshifted lane, and one that saturated at the wrong point would leave stray bytes. Sources with a distinct value in every byte expose any shift done across the whole vector rather than per lane, because such a design pulls a neighbour's low byte into the top of a lane. The bench crosses every width code, including the spare 2'b11, with both settings of the preserve flag. A design that honoured the flag at wider widths, shifted the source instead of the prior value, or zeroed the wrong upper range would give a result that differs from the bench's byte-level model.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [1:0] {
    LBS_W128 = 2'b00,
    LBS_W256 = 2'b01,
    LBS_W512 = 2'b10,
    LBS_WRSV = 2'b11
  } lbs_width_e;
endpackage

// File: rtl/lbs_lane_ctrl.sv
module lbs_lane_ctrl
  import lbs_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [1:0]           width_sel,
  input  logic                 keep_upper,
  output logic [NUM_LANES-1:0] lane_act,
  output logic                 preserve
);
  localparam int CW = $clog2(NUM_LANES + 1);

  lbs_width_e  width;
  logic [CW:0] n_act;

  always_comb begin
    width = lbs_width_e'(width_sel);
    case (width)
      LBS_W128: n_act = (CW+1)'(1);
      LBS_W256: n_act = (CW+1)'(2);
      default:  n_act = (CW+1)'(4);
    endcase
    if (n_act > (CW+1)'(NUM_LANES)) n_act = (CW+1)'(NUM_LANES);
    preserve = keep_upper && (width == LBS_W128);
    for (int i = 0; i < NUM_LANES; i++) begin
      lane_act[i] = ((CW+1)'(i) < n_act);
    end
  end
endmodule

// File: rtl/lbs_lane_shift.sv
module lbs_lane_shift #(
  parameter int LANE_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [CNT_W-1:0]  cnt,
  output logic [LANE_W-1:0] lane_out
);
  localparam int BYTES = LANE_W / 8;
  localparam int SH_W  = $clog2(BYTES);

  logic            sat;
  logic [SH_W-1:0] amt;
  logic [SH_W+2:0] bit_amt;

  always_comb begin
    sat      = (cnt >= CNT_W'(BYTES));
    amt      = cnt[SH_W-1:0];
    bit_amt  = {amt, 3'b000};
    lane_out = sat ? '0 : (lane_in >> bit_amt);
  end
endmodule

// File: rtl/lbs_out_stage.sv
module lbs_out_stage #(
  parameter int VEC_W   = 512,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] comb_res,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  if (REG_OUT) begin : g_reg
    logic             valid_d, valid_q;
    logic [VEC_W-1:0] data_d, data_q;
    logic             data_en;

    always_comb begin
      data_en = in_valid;
      valid_d = in_valid;
      data_d  = data_en ? comb_res : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_d;
        data_q  <= data_d;
      end
    end

    assign out_valid = valid_q;
    assign result    = data_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = comb_res;
  end
endmodule

// File: rtl/lane_bsr_top.sv
module lane_bsr_top #(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 8,
  parameter bit REG_OUT   = 1'b1,
  localparam int VEC_W    = LANE_W * NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] prior_dst,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [1:0]       width_sel,
  input  logic             keep_upper,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  logic [NUM_LANES-1:0] lane_act;
  logic                 preserve;
  logic [VEC_W-1:0]     comb_res;

  lbs_lane_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .width_sel (width_sel),
    .keep_upper(keep_upper),
    .lane_act  (lane_act),
    .preserve  (preserve)
  );

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] lane_sh;

    if (gi == 0) begin : g_first
      assign lane_in = preserve ? prior_dst[LANE_W-1:0] : src_vec[LANE_W-1:0];
    end else begin : g_rest
      assign lane_in = src_vec[gi*LANE_W +: LANE_W];
    end

    lbs_lane_shift #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_shift (
      .lane_in (lane_in),
      .cnt     (byte_cnt),
      .lane_out(lane_sh)
    );

    always_comb begin
      if (lane_act[gi])  comb_res[gi*LANE_W +: LANE_W] = lane_sh;
      else if (preserve) comb_res[gi*LANE_W +: LANE_W] = prior_dst[gi*LANE_W +: LANE_W];
      else               comb_res[gi*LANE_W +: LANE_W] = '0;
    end
  end

  lbs_out_stage #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .comb_res (comb_res),
    .out_valid(out_valid),
    .result   (result)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 8,
  parameter bit REG_OUT   = 1'b1,
  localparam int VEC_W    = LANE_W * NUM_LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] prior_dst,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [1:0]       width_sel,
  input logic             keep_upper,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam int BYTES = LANE_W / 8;

  if (REG_OUT && NUM_LANES >= 2) begin : g_chk
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result))); // R10
    AST_SAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_cnt > CNT_W'(BYTES - 1)) |=> (result[LANE_W-1:0] == '0)); // R3
    AST_TOP_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_cnt != '0) |=> (result[LANE_W-1 -: 8] == 8'h00)); // R2
    AST_ZERO_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && width_sel == 2'b00 && !keep_upper) |=> (result[VEC_W-1:LANE_W] == '0)); // R5
    AST_ZERO_ABOVE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && width_sel == 2'b01) |=> (result[VEC_W-1:2*LANE_W] == '0)); // R6
    AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && width_sel == 2'b00 && keep_upper)
        |=> (result[VEC_W-1:LANE_W] == $past(prior_dst[VEC_W-1:LANE_W]))); // R8
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid || !REG_OUT); // R11
    end
  end
endmodule

bind lane_bsr_top lbs_checker #(
  .LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .CNT_W(CNT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prior_dst(prior_dst),
  .byte_cnt(byte_cnt), .width_sel(width_sel), .keep_upper(keep_upper),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_lane_bsr_top.sv
`timescale 1ns/1ps
module tb_lane_bsr_top;
  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] src_vec, prior_dst;
  logic [7:0]    byte_cnt;
  logic [1:0]    width_sel;
  logic          keep_upper;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_bsr_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .prior_dst(prior_dst), .byte_cnt(byte_cnt), .width_sel(width_sel),
    .keep_upper(keep_upper), .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] model(logic [VW-1:0] s, logic [VW-1:0] p,
                                          logic [7:0] c, logic [1:0] w, logic k);
    logic [VW-1:0] r, x;
    int nl, n;
    r = '0;
    x = s;
    n = int'(c);
    nl = (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    if (w == 2'b00 && k) begin
      r = p;
      x[127:0] = p[127:0];
    end
    for (int l = 0; l < nl; l++) begin
      for (int b = 0; b < 16; b++) begin
        if (n < 16 && b + n < 16) r[l*128 + b*8 +: 8] = x[l*128 + (b+n)*8 +: 8];
        else                      r[l*128 + b*8 +: 8] = 8'h00;
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] ramp_vec(logic [7:0] base);
    logic [VW-1:0] v;
    for (int i = 0; i < VW/8; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [VW-1:0] s, logic [VW-1:0] p,
                       logic [7:0] c, logic [1:0] w, logic k);
    src_vec = s; prior_dst = p; byte_cnt = c; width_sel = w; keep_upper = k;
    in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " out_valid"}, {511'b0, out_valid}, {511'b0, 1'b1});
    chk(tag, result, model(s, p, c, w, k));
  endtask

  initial begin
    logic [VW-1:0] hold;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; prior_dst = '0;
    byte_cnt = '0; width_sel = '0; keep_upper = 1'b0;
    @(negedge clk); @(negedge clk);
    in_valid = 1'b1; src_vec = '1;
    @(negedge clk);
    chk("R11 reset out_valid", {511'b0, out_valid}, '0);
    chk("R11 reset result", result, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    apply("R1 count 0 w512", ramp_vec(8'h01), rand_vec(), 8'd0, 2'b10, 1'b0);
    apply("R1 count 5 w512", ramp_vec(8'h10), rand_vec(), 8'd5, 2'b10, 1'b0);
    apply("R2 count 15 fill", '1, rand_vec(), 8'd15, 2'b10, 1'b0);
    apply("R3 count 16 clears", '1, rand_vec(), 8'd16, 2'b10, 1'b0);
    apply("R3 count 255 clears", '1, rand_vec(), 8'd255, 2'b01, 1'b0);
    apply("R4 lane boundary", ramp_vec(8'h40), rand_vec(), 8'd1, 2'b10, 1'b0);
    apply("R5 w128 zero upper", '1, '1, 8'd3, 2'b00, 1'b0);
    apply("R6 w256 zero upper", ramp_vec(8'h80), '1, 8'd7, 2'b01, 1'b0);
    apply("R7 w code 11", ramp_vec(8'h33), rand_vec(), 8'd2, 2'b11, 1'b0);
    apply("R8 keep upper", ramp_vec(8'h01), ramp_vec(8'hA0), 8'd4, 2'b00, 1'b1);
    apply("R8 keep upper sat", rand_vec(), rand_vec(), 8'd200, 2'b00, 1'b1);
    apply("R9 keep ignored w256", rand_vec(), '1, 8'd6, 2'b01, 1'b1);
    apply("R9 keep ignored w512", rand_vec(), '1, 8'd9, 2'b10, 1'b1);

    hold = result;
    in_valid = 1'b0; src_vec = rand_vec(); byte_cnt = 8'd1;
    @(negedge clk);
    chk("R10 idle out_valid", {511'b0, out_valid}, '0);
    chk("R10 idle hold", result, hold);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 18);
      apply("R1 random", rand_vec(), rand_vec(), c, 2'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) begin
        hold = result;
        in_valid = 1'b0; src_vec = rand_vec();
        @(negedge clk);
        chk("R10 random idle", result, hold);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule